// File: doc/BRIEF.md
# Code-Density Nonlinearity Calibrator

This block measures and corrects the uneven bin widths of a tapped-delay-line time interpolator. During calibration it receives fine codes from events that have no timing relation to the reference clock. Such events fall evenly across one clock period, so the number of hits in each code bin is proportional to the width of that bin. When a fixed number of samples has been counted, the block turns the per-bin hit counts into a lookup table. The table gives, for each raw code, the position of that bin's centre inside the clock period. The position is a binary fraction of one period.

Calibration starts by itself when reset is released. It can be run again from the ready state with a one-cycle start pulse. Once the table is complete, each valid raw code is converted through the table in a single registered stage, so corrected offsets come out at the full measurement rate. A START interpolator and a STOP interpolator each use their own instance. The circuit that generates the random calibration events is outside this block.

Top module: `code_density_cal`

## Requirements
- R1: After reset is released, a calibration begins with no start pulse. `cal_done_o` and `ofs_valid_o` stay low from reset until the table is complete.
- R2: During collection, every valid code adds one to the hit count of its bin. Bins are numbered by code value 0..NBINS-1.
- R3: Collection takes exactly M = 2^LOG2_M valid samples. `cal_done_o` rises on the NBINS-th clock edge after the edge that accepts the M-th sample.
- R4: With total M and c_j the hit count of bin j, the table entry for bin k is floor(2^OFS_W · (2·Σ_{j<k} c_j + c_k) / (2M)). This is the bin centre as a fraction of one clock period.
- R5: While `cal_done_o` is high, a valid code produces `ofs_valid_o` high and the table entry on `ofs_o` one clock later. A cycle with no valid code gives `ofs_valid_o` low one clock later.
- R6: A code of NBINS or above is treated as bin NBINS-1, both when counting hits and when converting.
- R7: A `cal_start_i` pulse while `cal_done_o` is high lowers `cal_done_o` on the next edge and starts a fresh calibration from cleared counts. A pulse at any other time is ignored.
- R8: Table entries do not decrease with rising code. An entry whose exact value reaches a full period saturates at 2^OFS_W-1.
- R9: Valid codes are not counted in the clearing cycle or while the table is being built.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_start_i | input | 1 | Request a new calibration (accepted only when ready) |
| cal_done_o | output | 1 | Table complete, conversion active |
| code_valid_i | input | 1 | Raw code strobe |
| code_i | input | CODE_W | Raw fine code from the interpolator |
| ofs_valid_o | output | 1 | Corrected offset valid |
| ofs_o | output | OFS_W | Bin-centre offset in units of Tc/2^OFS_W |

## Verification
The embedded assertions check five properties on every cycle. No corrected offset may appear unless the block was ready one cycle before. A bin count may never exceed M, and the running sum may never exceed M. The build index must stay inside the table. Each written entry must be no smaller than the one written before it. The done flag may rise only out of the build phase, and an accepted restart must lower it. Only the bench scenarios can show that the entry values match the bin-centre formula. They also show the exact sample count and done timing, the clamping of out-of-range codes, the saturation of empty trailing bins, and that samples in the clearing and build cycles and stray start pulses leave the table unchanged.

// File: rtl/cdc_pkg.sv
package cdc_pkg;
  typedef enum logic [1:0] {
    S_CLEAR   = 2'd0,
    S_COLLECT = 2'd1,
    S_BUILD   = 2'd2,
    S_READY   = 2'd3
  } cal_state_e;
endpackage

// File: rtl/cdc_histogram.sv
module cdc_histogram #(
  parameter int NBINS  = 24,
  parameter int LOG2_M = 10,
  localparam int IDX_W = $clog2(NBINS),
  localparam int CNT_W = LOG2_M + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [CNT_W-1:0] rd_cnt_o
);
  localparam int M = 1 << LOG2_M;

  logic [CNT_W-1:0] cnt_q [NBINS];
  logic [CNT_W-1:0] cnt_d [NBINS];

  always_comb begin
    for (int b = 0; b < NBINS; b++) begin
      cnt_d[b] = cnt_q[b];
      if (clr_i)
        cnt_d[b] = '0;
      else if (inc_i && (int'(idx_i) == b))
        cnt_d[b] = cnt_q[b] + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBINS; b++) cnt_q[b] <= '0;
    end else begin
      for (int b = 0; b < NBINS; b++) cnt_q[b] <= cnt_d[b];
    end
  end

  assign rd_cnt_o = cnt_q[rd_idx_i];

  generate
    for (genvar g = 0; g < NBINS; g++) begin : g_bound
      // R2: the sample limit in the controller keeps each bin at or below M
      assert_bin_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q[g]) <= M);
    end
  endgenerate
endmodule

// File: rtl/cdc_table_builder.sv
module cdc_table_builder #(
  parameter int NBINS  = 24,
  parameter int LOG2_M = 10,
  parameter int OFS_W  = 8,
  localparam int IDX_W = $clog2(NBINS),
  localparam int CNT_W = LOG2_M + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             wr_en_o,
  output logic [OFS_W-1:0] wr_data_o,
  output logic             last_o
);
  localparam int M     = 1 << LOG2_M;
  localparam int NUM_W = LOG2_M + 2 + OFS_W;

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] cum_q, cum_d;
  logic [NUM_W-1:0] num, quot;
  logic [OFS_W-1:0] prev_q;

  always_comb begin
    num  = (NUM_W'(cum_q) << 1) + NUM_W'(cnt_i);
    quot = (num << OFS_W) >> (LOG2_M + 1);
    if (quot > NUM_W'((1 << OFS_W) - 1))
      wr_data_o = {OFS_W{1'b1}};
    else
      wr_data_o = quot[OFS_W-1:0];
  end

  always_comb begin
    idx_d = '0;
    cum_d = '0;
    if (run_i) begin
      idx_d = idx_q + IDX_W'(1);
      cum_d = cum_q + cnt_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      cum_q <= '0;
    end else begin
      idx_q <= idx_d;
      cum_q <= cum_d;
    end
  end

  assign rd_idx_o = idx_q;
  assign wr_en_o  = run_i;
  assign last_o   = run_i && (int'(idx_q) == NBINS - 1);

  // Reference for the monotonicity check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_q <= '0;
    else if (wr_en_o) prev_q <= wr_data_o;
  end

  assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (int'(idx_q) < NBINS));

  assert_sum_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cum_q) <= M);

  assert_monotone_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && (idx_q != '0)) |-> (wr_data_o >= prev_q));
endmodule

// File: rtl/cdc_lookup.sv
module cdc_lookup #(
  parameter int NBINS  = 24,
  parameter int OFS_W  = 8,
  localparam int IDX_W = $clog2(NBINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [OFS_W-1:0] wr_data_i,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             ofs_valid_o,
  output logic [OFS_W-1:0] ofs_o
);
  logic [OFS_W-1:0] tbl_q [NBINS];
  logic             vld_q;
  logic [OFS_W-1:0] ofs_q;

  always_ff @(posedge clk) begin
    if (wr_en_i) tbl_q[wr_idx_i] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (rd_en_i) ofs_q <= tbl_q[rd_idx_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= rd_en_i;
  end

  assign ofs_valid_o = vld_q;
  assign ofs_o       = ofs_q;
endmodule

// File: rtl/code_density_cal.sv
module code_density_cal
  import cdc_pkg::*;
#(
  parameter int CODE_W = 5,
  parameter int NBINS  = 24,
  parameter int LOG2_M = 10,
  parameter int OFS_W  = 8,
  localparam int IDX_W = $clog2(NBINS),
  localparam int CNT_W = LOG2_M + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_start_i,
  output logic              cal_done_o,
  input  logic              code_valid_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              ofs_valid_o,
  output logic [OFS_W-1:0]  ofs_o
);
  cal_state_e        state_q, state_d;
  logic [LOG2_M-1:0] samp_q, samp_d;
  logic [IDX_W-1:0]  code_idx, rd_idx;
  logic [CNT_W-1:0]  rd_cnt;
  logic              build_last, wr_en;
  logic [OFS_W-1:0]  wr_data;

  always_comb begin
    if (int'(code_i) >= NBINS) code_idx = IDX_W'(NBINS - 1);
    else                       code_idx = code_i[IDX_W-1:0];
  end

  always_comb begin
    state_d = state_q;
    samp_d  = samp_q;
    unique case (state_q)
      S_CLEAR: begin
        samp_d  = '0;
        state_d = S_COLLECT;
      end
      S_COLLECT: if (code_valid_i) begin
        samp_d = samp_q + LOG2_M'(1);
        if (samp_q == {LOG2_M{1'b1}}) state_d = S_BUILD;
      end
      S_BUILD: if (build_last) state_d = S_READY;
      S_READY: if (cal_start_i) state_d = S_CLEAR;
      default: state_d = S_CLEAR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_CLEAR;
      samp_q  <= '0;
    end else begin
      state_q <= state_d;
      samp_q  <= samp_d;
    end
  end

  assign cal_done_o = (state_q == S_READY);

  cdc_histogram #(.NBINS(NBINS), .LOG2_M(LOG2_M)) i_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (state_q == S_CLEAR),
    .inc_i    ((state_q == S_COLLECT) && code_valid_i),
    .idx_i    (code_idx),
    .rd_idx_i (rd_idx),
    .rd_cnt_o (rd_cnt)
  );

  cdc_table_builder #(.NBINS(NBINS), .LOG2_M(LOG2_M), .OFS_W(OFS_W)) i_build (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (state_q == S_BUILD),
    .cnt_i     (rd_cnt),
    .rd_idx_o  (rd_idx),
    .wr_en_o   (wr_en),
    .wr_data_o (wr_data),
    .last_o    (build_last)
  );

  cdc_lookup #(.NBINS(NBINS), .OFS_W(OFS_W)) i_lut (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en),
    .wr_idx_i    (rd_idx),
    .wr_data_i   (wr_data),
    .rd_en_i     ((state_q == S_READY) && code_valid_i),
    .rd_idx_i    (code_idx),
    .ofs_valid_o (ofs_valid_o),
    .ofs_o       (ofs_o)
  );

  assert_hold_invalid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_valid_o |-> $past(cal_done_o));

  assert_done_after_build_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_done_o) |-> $past(state_q == S_BUILD));

  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done_o && cal_start_i) |=> !cal_done_o);
endmodule

// File: tb/test_code_density_cal.sv
module test_code_density_cal;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 5;
  localparam int NB = 24;
  localparam int LM = 10;
  localparam int M  = 1 << LM;
  localparam int OW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_start = 1'b0;
  logic code_valid = 1'b0;
  logic [CW-1:0] code = '0;
  logic cal_done, ofs_valid;
  logic [OW-1:0] ofs;

  int n_chk = 0;
  int n_fail = 0;
  int hist [NB];

  always #(CLK_PERIOD / 2) clk = ~clk;

  code_density_cal #(.CODE_W(CW), .NBINS(NB), .LOG2_M(LM), .OFS_W(OW)) i_code_density_cal (
    .clk          (clk),
    .rst_n        (rst_n),
    .cal_start_i  (cal_start),
    .cal_done_o   (cal_done),
    .code_valid_i (code_valid),
    .code_i       (code),
    .ofs_valid_o  (ofs_valid),
    .ofs_o        (ofs)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bin_of(input int c);
    return (c >= NB) ? NB - 1 : c;
  endfunction

  function automatic int entry(input int k);
    int cum = 0;
    int e;
    for (int j = 0; j < k; j++) cum += hist[j];
    e = ((2 * cum + hist[k]) * (1 << OW)) / (2 * M);
    if (e > (1 << OW) - 1) e = (1 << OW) - 1;
    return e;
  endfunction

  // Inputs change 1 time unit after a rising edge; outputs are read there too.
  task automatic put(input bit s, input bit v, input int c);
    cal_start  = s;
    code_valid = v;
    code       = CW'(c);
    @(posedge clk);
    #1;
    cal_start  = 1'b0;
    code_valid = 1'b0;
  endtask

  // mode 0: random codes, 1: all zero plus a stray start, 2: two codes only
  task automatic calibrate(input int mode);
    int n = 0;
    for (int j = 0; j < NB; j++) hist[j] = 0;
    while (n < M) begin
      if ($urandom_range(3, 0) == 0) begin
        put(1'b0, 1'b0, int'($urandom_range(31, 0)));
      end else begin
        int c;
        bit s = 1'b0;
        if (mode == 0)      c = int'($urandom_range(31, 0));
        else if (mode == 1) c = 0;
        else                c = ($urandom_range(1, 0) == 0) ? 3 : 30;
        if (mode == 1 && n == M / 2) s = 1'b1; // R7: ignored while collecting
        hist[bin_of(c)]++;
        put(s, 1'b1, c);
        n++;
        if (n == 100) chk(!ofs_valid && !cal_done, "R1 outputs held during collect", int'(ofs_valid), 0);
      end
    end
    chk(!cal_done, "R3 done low right after last sample", int'(cal_done), 0);
    // R9: samples during build must not be counted
    for (int i = 0; i < NB - 1; i++) put(1'b0, 1'b1, 7);
    chk(!cal_done, "R3 done low one edge early", int'(cal_done), 0);
    put(1'b0, 1'b1, 7);
    chk(cal_done, "R3 done after NBINS edges", int'(cal_done), 1);
    chk(!ofs_valid, "R1 no output before ready", int'(ofs_valid), 0);
  endtask

  task automatic verify_table(input string tag);
    for (int c = 0; c < (1 << CW); c++) begin
      int e = entry(bin_of(c));
      put(1'b0, 1'b1, c);
      chk(ofs_valid, (c >= NB) ? "R6 valid (clamped code)" : "R5 valid", int'(ofs_valid), 1);
      if (c >= NB)
        chk(int'(ofs) == e, {"R6 clamp ", tag}, int'(ofs), e);
      else
        chk(int'(ofs) == e, {"R4 entry ", tag}, int'(ofs), e);
    end
    put(1'b0, 1'b0, 0);
    chk(!ofs_valid, "R5 idle gives no output", int'(ofs_valid), 0);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk(!cal_done && !ofs_valid, "R1 reset state", int'(cal_done), 0);
    rst_n = 1'b1;
    // R9: sample in clearing cycle is ignored
    put(1'b0, 1'b1, 9);
    // R1/R2/R3: automatic first calibration with random codes
    calibrate(0);
    verify_table("random");
    // R7: restart from ready
    put(1'b1, 1'b0, 0);
    chk(!cal_done, "R7 restart lowers done", int'(cal_done), 1'b0);
    put(1'b0, 1'b1, 9);
    // R8: all hits in bin 0 -> entry0 = half period, rest saturate
    calibrate(1);
    verify_table("all-zero");
    put(1'b0, 1'b1, 0);
    chk(int'(ofs) == (1 << (OW - 1)), "R8 bin0 centre", int'(ofs), 1 << (OW - 1));
    put(1'b0, 1'b1, 5);
    chk(int'(ofs) == (1 << OW) - 1, "R8 saturation", int'(ofs), (1 << OW) - 1);
    // R2/R6: sparse codes, 30 counts into last bin
    put(1'b1, 1'b0, 0);
    put(1'b0, 1'b0, 0);
    calibrate(2);
    verify_table("sparse");
    finish_run();
  end
endmodule